// File: doc/BRIEF.md
# Dual-Compare 8-bit PWM Timer

This block is an 8-bit timer/counter with two compare channels, A and B. Each channel has its own waveform output and its own match flag. The counter moves only on a timer tick. The tick is picked by a clock-source field and comes from one of two places: an enable pulse from an external prescaler, or a rising or falling edge on an asynchronous input pin. The pin is synchronized and edge-detected first. With no source selected, the counter is frozen.

There are four counting modes:

- Free-running count with wrap.
- Clear on a channel A match, which gives a variable period.
- Single-slope (fast) PWM.
- Dual-slope phase-correct PWM, which counts up to 0xFF and back down to zero.

Compare values are written into a buffer. In the two PWM modes the buffer reaches the comparator only at the top of the count, so a PWM period never sees a half-updated threshold.

Three sticky flags record overflow, match A and match B. Software clears a flag by writing a one to it. Each flag is gated by a mask bit to form its interrupt request.

A flat register port reaches the block. Writes are synchronous and reads are combinational. The map is:

| Address | Register | Notes |
|---|---|---|
| 0 | control | bits[1:0] mode, bits[3:2] source |
| 1 | counter | |
| 2 | compare A buffer | |
| 3 | compare B buffer | |
| 4 | mask | bit0 overflow, bit1 A, bit2 B |
| 5 | flags | same bit order as the mask |

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the counter, the control, mask and flag registers, both compare buffers and both waveform outputs read zero, and all interrupt requests are low.
- R2: Source code 0 (off) selects no tick, and the counter holds its value. Code 1 makes each cycle with `pre_tick` high advance the counter by one step.
- R3: Source code 2 counts rising edges of `ext_pin` and code 3 counts falling edges. The counter changes on the third rising clock edge after the pin changes. A level that stays constant never produces more than one step.
- R4: In mode 0 (normal) the counter counts up. A tick at 0xFF wraps it to 0x00 and sets the overflow flag (flag bit 0).
- R5: In mode 1 (clear on match) a tick with the counter equal to the active compare A value loads 0x00. A wrap from 0xFF also sets overflow.
- R6: A tick with the counter equal to a channel's active compare value sets that channel's flag (bit 1 for A, bit 2 for B). The two channels act independently.
- R7: Compare writes go to a buffer, and the buffer reads back at once. In modes 2 and 3 the buffer is copied to the active comparator only on a tick at 0xFF. In modes 0 and 1 it is copied on the next clock.
- R8: In mode 2 (fast PWM) a tick at 0xFF sets the channel output and wraps the counter. Otherwise a compare match clears the output.
- R9: In mode 3 (phase-correct) the counter rises to 0xFF, turns and falls to 0x00, then turns up again. A tick at 0x00 while counting down sets the overflow flag.
- R10: In mode 3 a match while counting up clears the channel output, and a match while counting down sets it.
- R11: In modes 0 and 1 each compare match toggles that channel's output.
- R12: Writing ones to the flag register clears those flags and leaves the others. Each interrupt request is high exactly when its flag and its mask bit are both set.
- R13: Writing the counter register loads the value and sets the count direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_tick | input | 1 | One-cycle enable from the external prescaler |
| ext_pin | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Channel A match interrupt request |
| irq_cmpb | output | 1 | Channel B match interrupt request |

## Verification
Most internal faults reach the ports within one tick. A wrong next-count or a wrong direction register shows in the counter read-back at the next tick. A stale or early active compare value shifts the edge of the PWM output, or the match flag, by whole tick counts. The slowest fault to appear is a double-buffer copy that happens at the wrong moment: it shows only when the count passes the old or new threshold, up to one full period (256 ticks, or 510 in phase-correct mode) later. For that reason the bench runs full periods in the buffer and phase tests. A broken synchronizer shows as a wrong edge latency or as a repeated step on a steady pin level.

// File: rtl/dct_pkg.sv
// Shared types and register map for the dual-compare timer.
// Assumes an 8-entry register address space; only six entries are decoded.
package dct_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_OFF      = 2'd0,
        SRC_PRE      = 2'd1,
        SRC_EXT_RISE = 2'd2,
        SRC_EXT_FALL = 2'd3
    } src_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd5;

    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = NUM_CH + 1;
    localparam int CTRL_W    = 4;
endpackage

// File: rtl/dct_tick_select.sv
// Produces the one-cycle timer tick from the selected source.
// Assumes ext_pin is asynchronous; it passes SYNC_STAGES flops, then one
// more flop holds the previous level for edge detection.
module dct_tick_select
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic pre_tick,
    input  logic ext_pin,
    output logic tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               pin_now;
    logic               pin_prev;

    // Shift the pin through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], ext_pin};
    end

    assign pin_now  = chain_q[SYNC_STAGES-1];
    assign pin_prev = chain_q[SYNC_STAGES];

    // Pick the tick according to the source field.
    always_comb begin
        case (src)
            SRC_PRE:      tick = pre_tick;
            SRC_EXT_RISE: tick = pin_now & ~pin_prev;
            SRC_EXT_FALL: tick = ~pin_now & pin_prev;
            default:      tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/dct_count_core.sv
// Counter with direction control for all four modes.
// Assumes load_en (a software write) takes priority over a tick.
module dct_count_core
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  mode_e        mode,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] clear_at,
    output logic [W-1:0] cnt,
    output logic         dir_up,
    output logic         at_top,
    output logic         ovf_evt
);
    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] BOTTOM = '0;

    logic [W-1:0] cnt_d;
    logic         dir_d;

    assign at_top = (cnt == TOP);

    // Overflow: the wrap at TOP, or the bottom turn in phase-correct mode.
    always_comb begin
        if (mode == MODE_PHASE) ovf_evt = tick && !dir_up && (cnt == BOTTOM);
        else                    ovf_evt = tick && (cnt == TOP);
    end

    // Next count and direction.
    always_comb begin
        cnt_d = cnt;
        dir_d = (mode == MODE_PHASE) ? dir_up : 1'b1;
        if (load_en) begin
            cnt_d = load_val;
            dir_d = 1'b1;
        end else if (tick) begin
            case (mode)
                MODE_CTC: cnt_d = (cnt == clear_at) ? BOTTOM : cnt + 1'b1;
                MODE_PHASE: begin
                    if (dir_up) begin
                        if (cnt == TOP) begin
                            dir_d = 1'b0;
                            cnt_d = cnt - 1'b1;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end else begin
                        if (cnt == BOTTOM) begin
                            dir_d = 1'b1;
                            cnt_d = cnt + 1'b1;
                        end else begin
                            cnt_d = cnt - 1'b1;
                        end
                    end
                end
                default: cnt_d = cnt + 1'b1;
            endcase
        end
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else begin
            cnt    <= cnt_d;
            dir_up <= dir_d;
        end
    end
endmodule

// File: rtl/dct_cmp_channel.sv
// One compare channel: buffer, active comparator and waveform output.
// Assumes the counter value and direction are the pre-tick values.
module dct_cmp_channel
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_we,
    input  logic [W-1:0] buf_wdata,
    input  mode_e        mode,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         dir_up,
    input  logic         at_top,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] active_q,
    output logic         match_evt,
    output logic         wave
);
    logic pwm;

    assign pwm       = (mode == MODE_FAST) || (mode == MODE_PHASE);
    assign match_evt = tick && (cnt == active_q);

    // Software-visible buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (buf_we) buf_q <= buf_wdata;
    end

    // Active value: follows the buffer, or loads only at TOP in PWM modes.
    always_ff @(posedge clk) begin
        if (!rst_n)                active_q <= '0;
        else if (!pwm)             active_q <= buf_q;
        else if (tick && at_top)   active_q <= buf_q;
    end

    // Waveform output per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            case (mode)
                MODE_FAST: begin
                    if (tick && at_top) wave <= 1'b1;
                    else if (match_evt) wave <= 1'b0;
                end
                MODE_PHASE: if (match_evt) wave <= !dir_up;
                default:    if (match_evt) wave <= !wave;
            endcase
        end
    end
endmodule

// File: rtl/dual_cmp_timer.sv
// Top: register port, flags, masks, and wiring of tick, counter and channels.
// Assumes one register access per cycle on each port; reads are combinational.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_tick,
    input  logic              ext_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq_ovf,
    output logic              irq_cmpa,
    output logic              irq_cmpb
);
    logic [CTRL_W-1:0]    ctrl_q;
    logic [NUM_FLAGS-1:0] mask_q;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_set;
    mode_e                mode;
    src_e                 src;
    logic                 tick;
    logic                 cnt_load;
    logic [W-1:0]         cnt;
    logic                 dir_up;
    logic                 at_top;
    logic                 ovf_evt;
    logic [W-1:0]         buf_q    [NUM_CH];
    logic [W-1:0]         active_q [NUM_CH];
    logic                 match    [NUM_CH];
    logic                 wave     [NUM_CH];

    assign mode     = mode_e'(ctrl_q[1:0]);
    assign src      = src_e'(ctrl_q[3:2]);
    assign cnt_load = wr_en && (wr_addr == ADR_COUNT);
    assign flag_clr = (wr_en && (wr_addr == ADR_FLAG)) ? wr_data[NUM_FLAGS-1:0] : '0;

    dct_tick_select #(.SYNC_STAGES(2)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .pre_tick (pre_tick),
        .ext_pin  (ext_pin),
        .tick     (tick)
    );

    dct_count_core #(.W(W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .load_en  (cnt_load),
        .load_val (wr_data),
        .clear_at (active_q[0]),
        .cnt      (cnt),
        .dir_up   (dir_up),
        .at_top   (at_top),
        .ovf_evt  (ovf_evt)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(int'(ADR_CMPA) + ch);
        dct_cmp_channel #(.W(W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .buf_we    (wr_en && (wr_addr == MY_ADR)),
            .buf_wdata (wr_data),
            .mode      (mode),
            .tick      (tick),
            .cnt       (cnt),
            .dir_up    (dir_up),
            .at_top    (at_top),
            .buf_q     (buf_q[ch]),
            .active_q  (active_q[ch]),
            .match_evt (match[ch]),
            .wave      (wave[ch])
        );
        assign flag_set[ch+1] = match[ch];
    end

    assign flag_set[0] = ovf_evt;

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_addr == ADR_MASK) mask_q <= wr_data[NUM_FLAGS-1:0];
        end
    end

    // Sticky flags: an event wins over a same-cycle write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_addr)
            ADR_CTRL:  rd_data = {{(W-CTRL_W){1'b0}}, ctrl_q};
            ADR_COUNT: rd_data = cnt;
            ADR_CMPA:  rd_data = buf_q[0];
            ADR_CMPB:  rd_data = buf_q[1];
            ADR_MASK:  rd_data = {{(W-NUM_FLAGS){1'b0}}, mask_q};
            ADR_FLAG:  rd_data = {{(W-NUM_FLAGS){1'b0}}, flags_q};
            default:   rd_data = '0;
        endcase
    end

    assign wave_a   = wave[0];
    assign wave_b   = wave[1];
    assign irq_ovf  = flags_q[0] & mask_q[0];
    assign irq_cmpa = flags_q[1] & mask_q[1];
    assign irq_cmpb = flags_q[2] & mask_q[2];
endmodule

// File: rtl/dct_checker.sv
// Property checker for dual_cmp_timer, attached with bind.
// Assumes the internal tick, counter, direction, active A and flag signals.
module dct_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [1:0]   src,
    input logic [1:0]   mode,
    input logic [W-1:0] cnt,
    input logic         dir_up,
    input logic         load,
    input logic [W-1:0] active_a,
    input logic [2:0]   flags,
    input logic [2:0]   flag_clr
);
    localparam logic [W-1:0] TOP = '1;

    // R2: no tick and no write leaves the counter unchanged.
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    // R4: a normal-mode wrap lands on zero and raises overflow.
    a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode == 2'd0 && cnt == TOP) |=> (cnt == '0 && flags[0]));

    // R5: a clear-on-match hit reloads zero.
    a_r5_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode == 2'd1 && cnt == active_a) |=> (cnt == '0));

    // R9: counting down steps by exactly one.
    a_r9_phase_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode == 2'd3 && !dir_up && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R9: the top of the count turns the direction.
    a_r9_phase_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode == 2'd3 && dir_up && cnt == TOP) |=> !dir_up);

    // R7: in PWM modes the active value moves only on a tick at TOP.
    a_r7_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !(tick && cnt == TOP)) |=> $stable(active_a));

    // R3: an edge source never yields ticks on two cycles in a row.
    a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && src[1]) |=> (!tick || !src[1]));

    // R12: a flag stays set until a write-one clear.
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !flag_clr[0]) |=> flags[0]);
endmodule

bind dual_cmp_timer dct_checker #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .src      (ctrl_q[3:2]),
    .mode     (ctrl_q[1:0]),
    .cnt      (cnt),
    .dir_up   (dir_up),
    .load     (cnt_load),
    .active_a (active_q[0]),
    .flags    (flags_q),
    .flag_clr (flag_clr)
);

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wave_a, wave_b, irq_ovf, irq_cmpa, irq_cmpb;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    dual_cmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wave_a(wave_a), .wave_b(wave_b),
        .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_CA = 3'd2,
                           A_CB = 3'd3, A_MASK = 3'd4, A_FLAG = 3'd5;

    // {src, mode, start, cmpa, cmpb, ticks, expected count, expected flags {B,A,ovf}}
    localparam int NV = 9;
    localparam logic [54:0] VECS [NV] = '{
        {2'd1, 2'd0, 8'hFD, 8'h10, 8'hFE, 16'd4,   8'h01, 3'b101},
        {2'd1, 2'd0, 8'h0E, 8'h0F, 8'h20, 16'd3,   8'h11, 3'b010},
        {2'd1, 2'd1, 8'h00, 8'h03, 8'h02, 16'd6,   8'h02, 3'b110},
        {2'd1, 2'd1, 8'hFE, 8'h05, 8'h00, 16'd3,   8'h01, 3'b101},
        {2'd1, 2'd2, 8'hFD, 8'h40, 8'h41, 16'd3,   8'h00, 3'b001},
        {2'd1, 2'd3, 8'hFD, 8'hFE, 8'h10, 16'd4,   8'hFD, 3'b010},
        {2'd1, 2'd3, 8'h02, 8'h01, 8'h50, 16'd2,   8'h04, 3'b000},
        {2'd1, 2'd3, 8'hFE, 8'h80, 8'h01, 16'd257, 8'h01, 3'b111},
        {2'd0, 2'd0, 8'h33, 8'h01, 8'h02, 16'd5,   8'h33, 3'b000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) pre_tick = 1'b1;
            @(negedge clk) pre_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string row_tag(input logic [1:0] s, input logic [1:0] m);
        if (s == 2'd0) return "R2";
        case (m)
            2'd0: return "R4 R6";
            2'd1: return "R5 R6";
            2'd2: return "R8 R6";
            default: return "R9 R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [54:0] v;
        do_reset();

        // R1: reset state
        rd(A_CNT, d);  chk("R1 count", d, 8'h00);
        rd(A_FLAG, d); chk("R1 flags", d, 8'h00);
        rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
        rd(A_CA, d);   chk("R1 cmpa", d, 8'h00);
        chk("R1 waves+irqs", {wave_a, wave_b, irq_ovf, irq_cmpa, irq_cmpb}, 5'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            wr(A_CTRL, 8'h00);
            wr(A_CA, v[42:35]);
            wr(A_CB, v[34:27]);
            wr(A_CNT, v[50:43]);
            wr(A_FLAG, 8'h07);
            wr(A_CTRL, {4'h0, v[54:53], v[52:51]});
            pulse(int'(v[26:11]));
            rd(A_CNT, d);  chk($sformatf("%s vec%0d count", row_tag(v[54:53], v[52:51]), i), d, v[10:3]);
            rd(A_FLAG, d); chk($sformatf("%s vec%0d flags", row_tag(v[54:53], v[52:51]), i), d, {5'b0, v[2:0]});
        end

        // R3: external rising edge, latency and single step
        do_reset();
        wr(A_CTRL, 8'h08);
        wr(A_CNT, 8'h00);
        @(negedge clk) ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_CNT, d); chk("R3 latency before third edge", d, 8'h00);
        @(negedge clk);
        rd(A_CNT, d); chk("R3 rise counted", d, 8'h01);
        repeat (6) @(negedge clk);
        rd(A_CNT, d); chk("R3 steady high one step", d, 8'h01);
        ext_pin = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R3 fall ignored in rise mode", d, 8'h01);
        wr(A_CTRL, 8'h0C);
        ext_pin = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R3 rise ignored in fall mode", d, 8'h01);
        ext_pin = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R3 fall counted", d, 8'h02);

        // R8: fast PWM waveform
        do_reset();
        wr(A_CA, 8'h02);
        wr(A_CTRL, 8'h06);
        wr(A_CNT, 8'hFF);
        pulse(1);
        chk("R8 set at top", wave_a, 1'b1);
        pulse(2);
        chk("R8 high before match", wave_a, 1'b1);
        pulse(1);
        chk("R8 cleared on match", wave_a, 1'b0);
        chk("R8 channel B cleared at zero match", wave_b, 1'b0);

        // R7: buffered compare in fast PWM (count is 3, active A is 2)
        wr(A_CA, 8'h10);
        rd(A_CA, d); chk("R7 buffer readback", d, 8'h10);
        wr(A_FLAG, 8'h07);
        pulse(252);
        rd(A_FLAG, d); chk("R7 no early match A", d[1], 1'b0);
        pulse(1);
        chk("R7 wave set at top", wave_a, 1'b1);
        pulse(16);
        chk("R7 old threshold unused", wave_a, 1'b1);
        pulse(1);
        chk("R7 new threshold clears", wave_a, 1'b0);
        rd(A_FLAG, d); chk("R6 flags after period", d, 8'h07);

        // R12: masking and write-one clear
        chk("R12 all masked", {irq_ovf, irq_cmpa, irq_cmpb}, 3'b000);
        wr(A_MASK, 8'h02);
        chk("R12 mask A only", {irq_ovf, irq_cmpa, irq_cmpb}, 3'b010);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, d); chk("R12 clear A only", d, 8'h05);
        chk("R12 irq A dropped", irq_cmpa, 1'b0);

        // R10, R9: phase-correct waveform and bottom overflow
        do_reset();
        wr(A_CA, 8'h03);
        wr(A_CTRL, 8'h07);
        wr(A_CNT, 8'hFE);
        pulse(2);
        rd(A_CNT, d); chk("R9 turned at top", d, 8'hFE);
        pulse(251);
        rd(A_CNT, d); chk("R9 down to 3", d, 8'h03);
        chk("R10 low before down match", wave_a, 1'b0);
        pulse(1);
        chk("R10 set on down match", wave_a, 1'b1);
        pulse(5);
        rd(A_CNT, d); chk("R9 turned at bottom", d, 8'h03);
        rd(A_FLAG, d); chk("R9 bottom overflow", d[0], 1'b1);
        chk("R10 still high", wave_a, 1'b1);
        pulse(1);
        chk("R10 cleared on up match", wave_a, 1'b0);

        // R13: count write restores up direction (counter currently rising)
        pulse(251);
        rd(A_CNT, d); chk("R13 reached top", d, 8'hFF);
        pulse(2);
        wr(A_CNT, 8'h40);
        pulse(1);
        rd(A_CNT, d); chk("R13 direction up after write", d, 8'h41);

        // R11: toggle in clear-on-match mode
        do_reset();
        wr(A_CA, 8'h02);
        wr(A_CB, 8'h01);
        wr(A_CTRL, 8'h05);
        pulse(3);
        chk("R11 both toggled", {wave_a, wave_b}, 2'b11);
        rd(A_CNT, d); chk("R5 reload zero", d, 8'h00);
        pulse(3);
        chk("R11 both toggled back", {wave_a, wave_b}, 2'b00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule